// File: doc/BRIEF.md
# Thermal Throttle Controller

This block decides how hard a processor must throttle itself to stay within its thermal limit. It compares a digital die-temperature reading with a programmable activation threshold. It also watches an external hot request arriving on a shared pin. From these it produces a performance-state index, which stands for a frequency-ratio and voltage pair where 0 is the fastest pair. It also produces a clock-modulation enable, a hot indication with an output enable for the shared pin, a sticky critical-temperature flag and an interrupt pulse.

While the die is hot, the index moves one level slower each step interval, until it reaches a configured lowest level. A reading that reaches a fixed margin above the threshold forces the emergency mode. In that mode clock modulation is on and the slowest level is used. When the die cools, the block waits out a hysteresis interval, or leaves the emergency mode at once. It then walks the index back towards 0 one level per step interval. Emergency mode that lasts longer than a parameterised window, derived from the clock frequency to equal 20 ms, marks the cooling solution as failed. The temperature sensor, the voltage regulator and the clock gating itself are outside the block.

Top module: `thermal_throttle_ctrl`

## Requirements
- R1: After reset, the index is 0 and clock modulation, the critical flag, the hot indication, the pin output enable and the interrupt are all low.
- R2: When `temp_i >= thresh_i`, the controller leaves idle on the next clock edge. From then on, while the trigger holds, the index rises by one every `step_ivl_i` cycles. The first step comes `step_ivl_i` cycles after activation, and the index stops at `lowest_ps_i`.
- R3: While stepping down, a reading of at least `thresh_i + MARGIN` (MARGIN = 5 by default) switches on clock modulation on the next edge and sets the index to `lowest_ps_i`. A reading below that level never switches on clock modulation.
- R4: Emergency mode persists until the trigger drops. Clock modulation then turns off on the next edge with the index unchanged, and the index falls by one every `step_ivl_i` cycles until it reaches 0.
- R5: While stepping down, recovery starts only after `hyst_ivl_i` consecutive cycles without a trigger. Any trigger cycle restarts that count.
- R6: After more than CRIT_CYCLES = CLK_HZ/50 consecutive cycles in emergency mode, `crit_o` goes high. It stays high until a `crit_clr_i` pulse, and a set in the same cycle takes priority over the clear.
- R7: `hot_pin_i` passes through a two-flop synchronizer. It acts as a trigger only while `bidir_en_i` is 1, and it is ignored otherwise.
- R8: `hot_o` equals the internal comparison `temp_i >= thresh_i`, registered once. `hot_oe_o` is high only while `bidir_en_i` and `hot_o` are both 1.
- R9: `irq_o` is a one-cycle pulse on a change of `hot_o`, in the same cycle as the change. The field `irq_mode_i[0]` enables it on the rising edge and `irq_mode_i[1]` on the falling edge.
- R10: A trigger during the step-up returns the controller to stepping down from the current index. The next step down comes `step_ivl_i` cycles later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| temp_i | input | TEMP_W | Die temperature reading |
| thresh_i | input | TEMP_W | Activation threshold |
| lowest_ps_i | input | PS_W | Slowest allowed performance-state index |
| step_ivl_i | input | CNT_W | Cycles between index steps |
| hyst_ivl_i | input | CNT_W | Cool cycles required before recovery |
| bidir_en_i | input | 1 | Shared hot pin acts as input and driven output |
| hot_pin_i | input | 1 | External hot request, asynchronous, active high |
| irq_mode_i | input | 2 | Bit 0 rising, bit 1 falling interrupt enable |
| crit_clr_i | input | 1 | Write-one-to-clear for the critical flag |
| ps_o | output | PS_W | Performance-state index, 0 fastest |
| clkmod_o | output | 1 | Clock modulation enable |
| hot_o | output | 1 | Internal hot indication |
| hot_oe_o | output | 1 | Output enable for the shared hot pin |
| crit_o | output | 1 | Sticky critical-temperature flag |
| irq_o | output | 1 | Hot-edge interrupt pulse |

## Verification
Every cycle, the assertions check these properties:
- Outside emergency mode, the index only moves by single steps.
- Clock modulation always starts at the slowest level and leaves without changing the index.
- The critical flag is sticky and can only rise after emergency mode held on the previous cycle.
- Every interrupt matches a change of the hot indication.

The exact step and hysteresis timing, the restart of the hysteresis count, the margin boundary, the critical window length, the gating of the external request and each interrupt mode can only be shown by the bench's directed scenarios.

// File: rtl/thermal_throttle_ctrl.sv
module thermal_throttle_ctrl #(
  parameter int TEMP_W = 8,
  parameter int PS_W   = 3,
  parameter int CNT_W  = 16,
  parameter int CLK_HZ = 250_000_000,
  parameter int MARGIN = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TEMP_W-1:0] temp_i,
  input  logic [TEMP_W-1:0] thresh_i,
  input  logic [PS_W-1:0]   lowest_ps_i,
  input  logic [CNT_W-1:0]  step_ivl_i,
  input  logic [CNT_W-1:0]  hyst_ivl_i,
  input  logic              bidir_en_i,
  input  logic              hot_pin_i,
  input  logic [1:0]        irq_mode_i,
  input  logic              crit_clr_i,
  output logic [PS_W-1:0]   ps_o,
  output logic              clkmod_o,
  output logic              hot_o,
  output logic              hot_oe_o,
  output logic              crit_o,
  output logic              irq_o
);
  localparam int CRIT_CYCLES = CLK_HZ / 50;
  localparam int CRIT_W      = $clog2(CRIT_CYCLES + 1);

  typedef enum logic [1:0] {S_IDLE, S_DOWN, S_COMB, S_UP} state_t;

  state_t            state_q;
  logic [PS_W-1:0]   ps_q;
  logic [CNT_W-1:0]  step_cnt, hyst_cnt;
  logic [CRIT_W-1:0] crit_cnt;
  logic [1:0]        sync_q;
  logic              crit_q, hot_q, irq_q;

  wire               hot_int   = temp_i >= thresh_i;
  wire [TEMP_W:0]    emerg_lvl = {1'b0, thresh_i} + (TEMP_W+1)'(MARGIN);
  wire               emerg     = {1'b0, temp_i} >= emerg_lvl;
  wire               ext_hot   = bidir_en_i & sync_q[1];
  wire               trig      = hot_int | ext_hot;
  wire               step_done = ({1'b0, step_cnt} + 1'b1) >= {1'b0, step_ivl_i};
  wire               hyst_done = ({1'b0, hyst_cnt} + 1'b1) >= {1'b0, hyst_ivl_i};
  wire               at_low    = ps_q >= lowest_ps_i;
  wire               crit_set  = (state_q == S_COMB) && (crit_cnt == CRIT_W'(CRIT_CYCLES));

  assign ps_o     = ps_q;
  assign clkmod_o = state_q == S_COMB;
  assign hot_o    = hot_q;
  assign hot_oe_o = bidir_en_i & hot_q;
  assign crit_o   = crit_q;
  assign irq_o    = irq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      hot_q  <= 1'b0;
      irq_q  <= 1'b0;
      crit_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[0], hot_pin_i};
      hot_q  <= hot_int;
      irq_q  <= (irq_mode_i[0] & hot_int & ~hot_q) | (irq_mode_i[1] & ~hot_int & hot_q);
      if (crit_set)        crit_q <= 1'b1;
      else if (crit_clr_i) crit_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crit_cnt <= '0;
    end else if (state_q != S_COMB) begin
      crit_cnt <= '0;
    end else if (!crit_set) begin
      crit_cnt <= crit_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= S_IDLE;
      ps_q     <= '0;
      step_cnt <= '0;
      hyst_cnt <= '0;
    end else begin
      case (state_q)
        S_IDLE: begin
          step_cnt <= '0;
          hyst_cnt <= '0;
          if (trig) state_q <= S_DOWN;
        end
        S_DOWN: begin
          if (emerg) begin
            state_q <= S_COMB;
            ps_q    <= lowest_ps_i;
          end else if (trig) begin
            hyst_cnt <= '0;
            if (step_done) begin
              step_cnt <= '0;
              if (!at_low) ps_q <= ps_q + 1'b1;
            end else begin
              step_cnt <= step_cnt + 1'b1;
            end
          end else if (hyst_done) begin
            state_q  <= S_UP;
            step_cnt <= '0;
            hyst_cnt <= '0;
          end else begin
            hyst_cnt <= hyst_cnt + 1'b1;
          end
        end
        S_COMB: begin
          if (!trig) begin
            state_q  <= S_UP;
            step_cnt <= '0;
          end
        end
        default: begin
          if (trig) begin
            state_q  <= S_DOWN;
            step_cnt <= '0;
            hyst_cnt <= '0;
          end else if (ps_q == '0) begin
            state_q <= S_IDLE;
          end else if (step_done) begin
            step_cnt <= '0;
            ps_q     <= ps_q - 1'b1;
            if (ps_q == PS_W'(1)) state_q <= S_IDLE;
          end else begin
            step_cnt <= step_cnt + 1'b1;
          end
        end
      endcase
    end
  end
endmodule

module thermal_throttle_ctrl_chk #(
  parameter int PS_W = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic [PS_W-1:0] lowest_ps_i,
  input logic            crit_clr_i,
  input logic [PS_W-1:0] ps_o,
  input logic            clkmod_o,
  input logic            crit_o,
  input logic            hot_o,
  input logic            irq_o
);
  AST_SINGLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !clkmod_o |=> (clkmod_o || ps_o == $past(ps_o) || ps_o == $past(ps_o) + 1'b1 || ps_o + 1'b1 == $past(ps_o))); // R2
  AST_MOD_AT_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clkmod_o) |-> ps_o == lowest_ps_i); // R3
  AST_MOD_EXIT_KEEPS_PS: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(clkmod_o) |-> ps_o == $past(ps_o)); // R4
  AST_CRIT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (crit_o && !crit_clr_i) |=> crit_o); // R6
  AST_CRIT_AFTER_MOD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(crit_o) |-> $past(clkmod_o)); // R6
  AST_IRQ_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> hot_o != $past(hot_o)); // R9
endmodule

bind thermal_throttle_ctrl thermal_throttle_ctrl_chk #(.PS_W(PS_W)) u_chk (.*);

// File: tb/thermal_throttle_ctrl_test.sv
module thermal_throttle_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] temp_i = 8'd40, thresh_i = 8'd80;
  logic [2:0] lowest_ps_i = 3'd3;
  logic [15:0] step_ivl_i = 16'd4, hyst_ivl_i = 16'd6;
  logic       bidir_en_i = 1'b0, hot_pin_i = 1'b0, crit_clr_i = 1'b0;
  logic [1:0] irq_mode_i = 2'b01;
  logic [2:0] ps_o;
  logic       clkmod_o, hot_o, hot_oe_o, crit_o, irq_o;
  int n_chk = 0, n_bad = 0;

  thermal_throttle_ctrl #(.CLK_HZ(50_000)) uut (
    .clk(clk), .rst_n(rst_n), .temp_i(temp_i), .thresh_i(thresh_i),
    .lowest_ps_i(lowest_ps_i), .step_ivl_i(step_ivl_i), .hyst_ivl_i(hyst_ivl_i),
    .bidir_en_i(bidir_en_i), .hot_pin_i(hot_pin_i), .irq_mode_i(irq_mode_i),
    .crit_clr_i(crit_clr_i), .ps_o(ps_o), .clkmod_o(clkmod_o), .hot_o(hot_o),
    .hot_oe_o(hot_oe_o), .crit_o(crit_o), .irq_o(irq_o));

  always #2 clk = ~clk;

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cool_down();
    temp_i = 8'd40; hot_pin_i = 1'b0; bidir_en_i = 1'b0;
    tick(40);
  endtask

  task automatic t_reset();
    check("R1 ps", ps_o, 0); check("R1 clkmod", clkmod_o, 0);
    check("R1 crit", crit_o, 0); check("R1 hot", hot_o, 0);
    check("R1 oe", hot_oe_o, 0); check("R1 irq", irq_o, 0);
  endtask

  task automatic t_step_down();
    irq_mode_i = 2'b01; temp_i = 8'd82;
    tick(1); check("R9 rise irq", irq_o, 1); check("R8 hot", hot_o, 1);
    tick(1); check("R9 pulse end", irq_o, 0);
    tick(2); check("R2 before step", ps_o, 0);
    tick(1); check("R2 step1", ps_o, 1);
    tick(4); check("R2 step2", ps_o, 2);
    tick(4); check("R2 step3", ps_o, 3);
    tick(8); check("R2 saturate", ps_o, 3); check("R3 no mod", clkmod_o, 0);
  endtask

  task automatic t_hyst_and_up();
    temp_i = 8'd70; tick(4);
    temp_i = 8'd81; tick(2);
    temp_i = 8'd70;
    tick(9);  check("R5 restart hold", ps_o, 3);
    tick(1);  check("R4 up step", ps_o, 2);
    tick(4);  check("R4 up step2", ps_o, 1);
    tick(4);  check("R4 up to 0", ps_o, 0);
  endtask

  task automatic t_margin();
    temp_i = 8'd84; tick(20);
    check("R3 below margin", clkmod_o, 0); check("R3 below margin ps", ps_o, 3);
    temp_i = 8'd85; tick(1);
    check("R3 at margin mod", clkmod_o, 1); check("R3 at margin ps", ps_o, 3);
    temp_i = 8'd78; tick(1);
    check("R4 mod off", clkmod_o, 0); check("R4 no jump", ps_o, 3);
    tick(4); check("R4 stepwise", ps_o, 2);
    cool_down(); check("R4 idle", ps_o, 0);
  endtask

  task automatic t_emerg_from_idle();
    temp_i = 8'd86;
    tick(1); check("R3 not yet", clkmod_o, 0);
    tick(1); check("R3 mod", clkmod_o, 1); check("R3 lowest", ps_o, 3);
    cool_down();
  endtask

  task automatic t_critical();
    temp_i = 8'd90; tick(2);
    check("R3 comb", clkmod_o, 1);
    tick(900); check("R6 not yet", crit_o, 0);
    tick(200); check("R6 set", crit_o, 1);
    cool_down(); check("R6 sticky", crit_o, 1);
    crit_clr_i = 1'b1; tick(1); crit_clr_i = 1'b0;
    check("R6 clear", crit_o, 0);
    temp_i = 8'd90; tick(500);
    check("R6 short comb", crit_o, 0);
    cool_down();
  endtask

  task automatic t_external();
    bidir_en_i = 1'b0; hot_pin_i = 1'b1; tick(20);
    check("R7 ignored", ps_o, 0);
    hot_pin_i = 1'b0; tick(4);
    bidir_en_i = 1'b1; hot_pin_i = 1'b1;
    tick(6); check("R7 sync delay", ps_o, 0);
    tick(1); check("R7 ext step", ps_o, 1);
    check("R8 ext no hot", hot_o, 0); check("R8 ext no oe", hot_oe_o, 0);
    cool_down(); check("R7 release", ps_o, 0);
  endtask

  task automatic t_oe_irq();
    irq_mode_i = 2'b10; bidir_en_i = 1'b1; temp_i = 8'd81;
    tick(1); check("R8 oe", hot_oe_o, 1); check("R9 rise masked", irq_o, 0);
    bidir_en_i = 1'b0; #0;
    tick(1); check("R8 oe off", hot_oe_o, 0); check("R8 hot kept", hot_o, 1);
    temp_i = 8'd60;
    tick(1); check("R9 fall irq", irq_o, 1);
    tick(1); check("R9 fall end", irq_o, 0);
    cool_down();
    irq_mode_i = 2'b00; temp_i = 8'd81;
    tick(1); check("R9 none", irq_o, 0);
    cool_down();
    irq_mode_i = 2'b11; temp_i = 8'd81;
    tick(1); check("R9 both rise", irq_o, 1);
    temp_i = 8'd60;
    tick(1); tick(0); check("R9 both fall", irq_o, 1);
    cool_down();
  endtask

  task automatic t_reactivate();
    irq_mode_i = 2'b00; temp_i = 8'd82; tick(13);
    check("R10 at low", ps_o, 3);
    temp_i = 8'd70; tick(11);
    check("R10 stepped up", ps_o, 2);
    temp_i = 8'd82;
    tick(4); check("R10 hold", ps_o, 2);
    tick(1); check("R10 down again", ps_o, 3);
    cool_down();
  endtask

  initial begin
    #(4 * 150_000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    tick(3);
    t_reset();
    rst_n = 1'b1;
    tick(2);
    t_reset();
    t_step_down();
    t_hyst_and_up();
    temp_i = 8'd82; tick(13);
    t_margin();
    t_emerg_from_idle();
    t_critical();
    t_external();
    t_oe_irq();
    t_reactivate();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule